// File: doc/BRIEF.md
# Serial Coefficient Loader

This block fills a bank of filter coefficients one value at a time. Each time the load strobe is high at a rising clock edge, the 8-bit signed value on the coefficient input is stored in the next free slot of a packed parallel bus. An internal write index chooses that slot. It starts at slot 0 and advances by one after every accepted value.

Once the last slot has been written, a registered ready flag goes high. The downstream filter uses this flag to start shifting samples and computing outputs. From then on the bank is locked: further load strobes have no effect until the asynchronous clear returns the block to its empty state.

The default build holds six coefficients, one for each symmetric tap pair of a twelve-tap filter. The slot count and the coefficient width are parameters.

Top module: `coef_serial_loader`

## Requirements
- R1: While the asynchronous clear (active high) is asserted, the coefficient bus reads all zeros and the ready flag is low, with no clock edge needed; the write index returns to slot 0.
- R2: Slot j occupies bits [(j+1)*8-1 : j*8] of the coefficient bus. The first value accepted after clear goes to slot 0, the next to slot 1, and so on up to slot 5.
- R3: A value is captured only on a rising clock edge at which the load strobe is high. Edges with the strobe low change neither the bus nor the write index.
- R4: The ready flag stays low until the edge that writes slot 5. It is high from that edge onward, registered and not combinational from the strobe.
- R5: Once high, the ready flag stays high on every later edge until the next clear.
- R6: Load strobes that arrive while the ready flag is high are ignored, and the coefficient bus keeps its contents.
- R7: A clear asserted part-way through loading discards the partial contents. Loading then restarts at slot 0.
- R8: Values are stored bit-exact as two's-complement, including the extremes -128 and +127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrAsync | input | 1 | Asynchronous clear, active high |
| loadStrobe | input | 1 | Capture the value on coefIn at this edge |
| coefIn | input | 8 | Signed coefficient value |
| coefBus | output | 48 | Packed coefficients, slot j at bits [(j+1)*8-1 : j*8] |
| coefReady | output | 1 | High once every slot has been written |

## Verification
The embedded properties check the following on every clocked cycle:
- the write index stays in range and steps by exactly one per accepted strobe;
- the ready flag rises only together with the write to the last slot, and never falls outside a clear;
- the bus stays frozen when nothing is captured or once the block is locked.

Other behaviours can only be shown by the directed scenarios:
- which slot each value lands in, and that negative extremes survive bit-exact;
- that clear acts between clock edges;
- that a reload after a mid-fill clear starts again from slot 0.

// File: rtl/coef_load_pkg.sv
package coef_load_pkg;

  // Strobes from the control to the slot bank
  typedef struct packed {
    logic capture;   // write coefIn into the selected slot at this edge
    logic complete;  // this capture fills the last slot
  } loadStrb_t;

endpackage

// File: rtl/coef_load_ctrl.sv
module coef_load_ctrl
  import coef_load_pkg::*;
#(
  parameter int NUM_COEF = 6,
  localparam int IDX_W = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic             clk,
  input  logic             clrAsync,
  input  logic             loadStrobe,
  output loadStrb_t        strb,
  output logic [IDX_W-1:0] slotIdx,
  output logic             coefReady
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);

  logic [IDX_W-1:0] idxQ;
  logic             readyQ;
  logic             atLast;

  assign atLast        = (idxQ == LAST_IDX);
  assign strb.capture  = loadStrobe && !readyQ;
  assign strb.complete = strb.capture && atLast;

  always_ff @(posedge clk or posedge clrAsync) begin
    if (clrAsync) begin
      idxQ   <= '0;
      readyQ <= 1'b0;
    end else if (strb.capture) begin
      if (!atLast) idxQ <= idxQ + 1'b1;
      if (strb.complete) readyQ <= 1'b1;
    end
  end

  assign slotIdx   = idxQ;
  assign coefReady = readyQ;

  // R2: the write index never leaves the slot range
  p_idx_range_r2: assert property (@(posedge clk) disable iff (clrAsync)
    idxQ <= LAST_IDX);

  // R3: the index advances by one after each accepted strobe that is not the last
  p_idx_step_r3: assert property (@(posedge clk) disable iff (clrAsync)
    (loadStrobe && !readyQ && !atLast) |=> (idxQ == $past(idxQ) + 1'b1));

  // R3: no strobe means the index holds
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (clrAsync)
    !loadStrobe |=> $stable(idxQ));

  // R4: ready rises only after a strobe accepted at the last slot
  p_ready_rise_r4: assert property (@(posedge clk) disable iff (clrAsync)
    $rose(readyQ) |-> ($past(loadStrobe) && $past(idxQ) == LAST_IDX));

  // R5: ready is sticky until clear
  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (clrAsync)
    readyQ |=> readyQ);

endmodule

// File: rtl/coef_slot_bank.sv
module coef_slot_bank
  import coef_load_pkg::*;
#(
  parameter int NUM_COEF = 6,
  parameter int COEF_W   = 8,
  localparam int IDX_W   = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1,
  localparam int BUS_W   = NUM_COEF * COEF_W
) (
  input  logic              clk,
  input  logic              clrAsync,
  input  loadStrb_t         strb,
  input  logic [IDX_W-1:0]  slotIdx,
  input  logic [COEF_W-1:0] coefIn,
  output logic [BUS_W-1:0]  coefBus
);

  for (genvar j = 0; j < NUM_COEF; j++) begin : g_slot
    logic [COEF_W-1:0] slotQ;

    always_ff @(posedge clk or posedge clrAsync) begin
      if (clrAsync)
        slotQ <= '0;
      else if (strb.capture && (slotIdx == IDX_W'(j)))
        slotQ <= coefIn;
    end

    assign coefBus[j*COEF_W +: COEF_W] = slotQ;
  end

  // R6: without a capture strobe the bank keeps its contents
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (clrAsync)
    !strb.capture |=> $stable(coefBus));

  // R4: completion comes only with a capture into the last slot
  p_complete_last_r4: assert property (@(posedge clk) disable iff (clrAsync)
    strb.complete |-> (strb.capture && slotIdx == IDX_W'(NUM_COEF - 1)));

endmodule

// File: rtl/coef_serial_loader.sv
module coef_serial_loader
  import coef_load_pkg::*;
#(
  parameter int NUM_COEF = 6,
  parameter int COEF_W   = 8,
  localparam int IDX_W   = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1,
  localparam int BUS_W   = NUM_COEF * COEF_W
) (
  input  logic                     clk,
  input  logic                     clrAsync,
  input  logic                     loadStrobe,
  input  logic signed [COEF_W-1:0] coefIn,
  output logic [BUS_W-1:0]         coefBus,
  output logic                     coefReady
);

  loadStrb_t        strb;
  logic [IDX_W-1:0] slotIdx;

  coef_load_ctrl #(.NUM_COEF(NUM_COEF)) u_ctrl (
    .clk        (clk),
    .clrAsync   (clrAsync),
    .loadStrobe (loadStrobe),
    .strb       (strb),
    .slotIdx    (slotIdx),
    .coefReady  (coefReady)
  );

  coef_slot_bank #(.NUM_COEF(NUM_COEF), .COEF_W(COEF_W)) u_bank (
    .clk      (clk),
    .clrAsync (clrAsync),
    .strb     (strb),
    .slotIdx  (slotIdx),
    .coefIn   (coefIn),
    .coefBus  (coefBus)
  );

  // R6: once ready, strobes leave the bus untouched
  p_locked_r6: assert property (@(posedge clk) disable iff (clrAsync)
    coefReady |=> $stable(coefBus));

  // R1: while clear is held the outputs are in their empty state
  always @(posedge clk) begin
    if (clrAsync) begin
      p_clear_state_r1: assert (coefBus == '0 && !coefReady);
    end
  end

endmodule

// File: tb/coef_serial_loader_tb.sv
`timescale 1ns/1ps
module coef_serial_loader_tb;

  localparam int N = 6;
  localparam int W = 8;

  logic               clk = 1'b0;
  logic               clrAsync = 1'b0;
  logic               loadStrobe = 1'b0;
  logic signed [W-1:0] coefIn = '0;
  logic [N*W-1:0]     coefBus;
  logic               coefReady;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] expSlot [N];

  always #2.5 clk = ~clk;

  coef_serial_loader #(.NUM_COEF(N), .COEF_W(W)) u_dut (
    .clk        (clk),
    .clrAsync   (clrAsync),
    .loadStrobe (loadStrobe),
    .coefIn     (coefIn),
    .coefBus    (coefBus),
    .coefReady  (coefReady)
  );

  function automatic logic [N*W-1:0] expBus();
    logic [N*W-1:0] b;
    for (int j = 0; j < N; j++) b[j*W +: W] = expSlot[j];
    return b;
  endfunction

  task automatic chk(string req, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearAll();
    @(negedge clk);
    clrAsync = 1'b1;
    #1;
    for (int j = 0; j < N; j++) expSlot[j] = '0;
    chk("R1 bus", coefBus, '0);
    chk("R1 ready", {47'd0, coefReady}, '0);
    @(negedge clk);
    clrAsync = 1'b0;
  endtask

  // one strobe; bench model advances its own index
  task automatic push(input logic [W-1:0] v, inout int idx);
    @(negedge clk);
    loadStrobe = 1'b1;
    coefIn = v;
    @(negedge clk);
    loadStrobe = 1'b0;
    if (idx < N) begin
      expSlot[idx] = v;
      idx++;
    end
  endtask

  task automatic t_fill_gapped();
    int idx = 0;
    clearAll();
    for (int k = 0; k < N; k++) begin
      chk("R4 ready low before last", {47'd0, coefReady}, '0);
      push(W'(8'h11 * (k + 1)), idx);
      // idle cycles with a changing value but no strobe
      @(negedge clk); coefIn = 8'h5A;
      @(negedge clk);
      chk("R3 idle edges ignored", coefBus, expBus());
    end
    chk("R2 slot layout", coefBus, expBus());
    chk("R2 slot0 field", {40'd0, coefBus[7:0]}, {40'd0, 8'h11});
    chk("R2 slot5 field", {40'd0, coefBus[47:40]}, {40'd0, 8'h66});
    chk("R4 ready after last", {47'd0, coefReady}, 48'd1);
  endtask

  task automatic t_late_loads();
    int idx = N;
    for (int k = 0; k < 3; k++) push(8'hEE, idx);
    chk("R6 late loads ignored", coefBus, expBus());
    repeat (4) @(negedge clk);
    chk("R5 ready sticky", {47'd0, coefReady}, 48'd1);
  endtask

  task automatic t_back_to_back_signed();
    int idx = 0;
    logic [W-1:0] vals [N];
    vals = '{8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00, 8'hC3};
    clearAll();
    @(negedge clk);
    loadStrobe = 1'b1;
    for (int k = 0; k < N; k++) begin
      coefIn = vals[k];
      expSlot[k] = vals[k];
      @(negedge clk);
      if (k < N - 1) chk("R4 ready low mid-burst", {47'd0, coefReady}, '0);
    end
    coefIn = 8'h55;
    @(negedge clk);
    loadStrobe = 1'b0;
    idx = N;
    chk("R8 signed extremes stored", coefBus, expBus());
    chk("R4 ready after burst", {47'd0, coefReady}, 48'd1);
    chk("R6 strobe held past last", coefBus, expBus());
  endtask

  task automatic t_clear_midway();
    int idx = 0;
    clearAll();
    push(8'hA1, idx);
    push(8'hA2, idx);
    push(8'hA3, idx);
    // asynchronous clear between edges
    @(negedge clk);
    #1 clrAsync = 1'b1;
    #0.5;
    chk("R1 async clear no edge", coefBus, '0);
    @(negedge clk);
    clrAsync = 1'b0;
    for (int j = 0; j < N; j++) expSlot[j] = '0;
    idx = 0;
    push(8'h3C, idx);
    chk("R7 restart at slot 0", coefBus, expBus());
    for (int k = 1; k < N; k++) push(W'(8'hB0 + k), idx);
    chk("R7 full reload", coefBus, expBus());
    chk("R7 ready after reload", {47'd0, coefReady}, 48'd1);
  endtask

  initial begin
    clrAsync = 1'b1;
    #1;
    chk("R1 reset bus", coefBus, '0);
    chk("R1 reset ready", {47'd0, coefReady}, '0);
    @(negedge clk);
    clrAsync = 1'b0;
    t_fill_gapped();
    t_late_loads();
    t_back_to_back_signed();
    t_clear_midway();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule